// File: doc/BRIEF.md
# Preemptive Virtual Channel Allocator

This block is the virtual-channel allocation stage for one output port of a router that provides quality of service and uses virtual cut-through flow control. Each cycle, the requesting packets compete on a priority value, where a smaller number means more urgent. The winner claims a downstream virtual channel (VC) that has room for a whole packet. After that, the packet streams out without any further switch arbitration. Allocation completes in the same cycle as the request.

When the winner finds no usable VC, it looks at the packets that hold the VCs. If one of them is strictly less urgent and may be preempted, the block discards it. It reports the discarded packet's source on a negative-acknowledge output, so that the source can send it again. The discarded VC returns to the free pool with full credits on the following cycle. VC 0 is reserved for rate-compliant packets, which are packets within their reserved quota. Rate-compliant packets are never chosen as victims.

Each VC holds one packet of up to `VC_DEPTH` flits. Downstream returns credits one flit at a time. A VC accepts a new packet only when all of its credits are back. The cycle in which the last credit returns is reported as a per-VC delivery pulse.

Top module: `vcPreemptAlloc`

## Requirements
- R1: After reset, every VC holds `VC_DEPTH` credits and is free. With no request present, `grantValid`, `nackValid` and `doneMask` are all 0.
- R2: Among the asserted `reqValid` bits, the requester with the smallest `reqPrio` value wins. Ties go to the lowest requester index. At most one grant is made per cycle, and it is shown combinationally in the request cycle on `grantValid`/`grantReq`/`grantVc`.
- R3: VC 0 is granted only to a rate-compliant winner (`reqCompliant`=1). Such a winner takes VC 0 when it is free, and otherwise the lowest-index free VC among 1..NUM_VC-1. A non-compliant winner takes the lowest-index free VC among 1..NUM_VC-1.
- R4: A VC is free only while its credit count equals `VC_DEPTH`. A grant takes `reqLen`+1 credits, where `reqLen` holds the packet length minus one in `$clog2(VC_DEPTH)` bits per requester. The VC then stays unusable by any later request, whatever its priority, until those credits return.
- R5: Each `creditRet[v]` pulse on a VC that is not full adds one credit. `doneMask[v]` is 1 in the cycle whose pulse brings the count back to `VC_DEPTH`.
- R6: A priority inversion occurs when a winner has no usable free VC and some usable VC holds a strictly less urgent, non-compliant packet. In that case the block asserts `nackValid` with `nackVc` and `nackSrc`, the original requester index of the victim, and makes no grant in that cycle.
- R7: The victim is the candidate VC with the largest stored priority value. Ties go to the lowest VC index.
- R8: No preemption occurs if every occupied candidate is rate-compliant, or if every candidate is no less urgent than the winner. In that case neither a grant nor a NACK is issued.
- R9: A preempted VC is free with full credits in the cycle after its NACK. A winner that is still requesting is granted that VC then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | NUM_REQ | Per-requester request strobe |
| reqPrio | input | NUM_REQ*PRIO_W | Packed priorities, requester i at bits i*PRIO_W; smaller is more urgent |
| reqCompliant | input | NUM_REQ | Packet is within its reserved rate quota |
| reqLen | input | NUM_REQ*LEN_W | Packet length minus one, LEN_W = $clog2(VC_DEPTH) |
| creditRet | input | NUM_VC | One returned credit per VC per cycle |
| grantValid | output | 1 | A VC is granted this cycle |
| grantReq | output | REQ_IW | Index of the granted requester |
| grantVc | output | VC_IW | Granted VC |
| nackValid | output | 1 | A packet is preempted this cycle |
| nackVc | output | VC_IW | VC of the preempted packet |
| nackSrc | output | REQ_IW | Requester that originally sent the preempted packet |
| doneMask | output | NUM_VC | Per-VC pulse when a packet's last credit returns |

## Verification
The bench builds the block with three requesters, four VCs of depth four and 3-bit priorities. This keeps every priority combination and valid mask of the arbiter small enough to sweep exhaustively (512 × 7 cases). With only three general VCs, scenarios that fill the port completely take a few cycles. That makes it possible to reach victim selection with ties, refusal of compliant victims, the reserved VC, and credit return for every packet length from one to four flits, with all expected values computed arithmetically.

// File: rtl/vcaPkg.sv
package vcaPkg;
  typedef struct packed {
    logic grantEn;
    logic dropEn;
  } vcaStrobe_t;

  function automatic int idxWidth(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/vcaCtrl.sv
module vcaCtrl
  import vcaPkg::*;
#(
  parameter int NUM_REQ  = 3,
  parameter int NUM_VC   = 4,
  parameter int PRIO_W   = 4,
  parameter int LEN_W    = 2,
  localparam int REQ_IW  = idxWidth(NUM_REQ),
  localparam int VC_IW   = idxWidth(NUM_VC)
) (
  input  logic [NUM_REQ-1:0]        reqValid,
  input  logic [NUM_REQ*PRIO_W-1:0] reqPrio,
  input  logic [NUM_REQ-1:0]        reqCompliant,
  input  logic [NUM_REQ*LEN_W-1:0]  reqLen,
  input  logic [NUM_VC-1:0]         vcFree,
  input  logic [NUM_VC*PRIO_W-1:0]  vcPrio,
  input  logic [NUM_VC-1:0]         vcComp,
  output vcaStrobe_t                strobe,
  output logic [REQ_IW-1:0]         winIdx,
  output logic [PRIO_W-1:0]         winPrio,
  output logic                      winComp,
  output logic [LEN_W-1:0]          winLen,
  output logic [VC_IW-1:0]          grantVc,
  output logic [VC_IW-1:0]          dropVc
);
  logic             winFound;
  logic             genFound;
  logic [VC_IW-1:0] genVc;
  logic             vicFound;
  logic [PRIO_W-1:0] vicPrio;

  // requester arbitration: smallest value, lowest index on ties
  always_comb begin
    winFound = 1'b0;
    winIdx   = '0;
    winPrio  = '0;
    winComp  = 1'b0;
    winLen   = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (reqValid[i] && (!winFound || reqPrio[i*PRIO_W +: PRIO_W] < winPrio)) begin
        winFound = 1'b1;
        winIdx   = REQ_IW'(i);
        winPrio  = reqPrio[i*PRIO_W +: PRIO_W];
        winComp  = reqCompliant[i];
        winLen   = reqLen[i*LEN_W +: LEN_W];
      end
    end
  end

  // lowest free general VC (index 0 is the reserved one)
  always_comb begin
    genFound = 1'b0;
    genVc    = '0;
    for (int v = NUM_VC - 1; v >= 1; v--) begin
      if (vcFree[v]) begin
        genFound = 1'b1;
        genVc    = VC_IW'(v);
      end
    end
  end

  // victim search over general VCs: worst priority, lowest index on ties
  always_comb begin
    vicFound = 1'b0;
    vicPrio  = '0;
    dropVc   = '0;
    for (int v = 1; v < NUM_VC; v++) begin
      if (!vcFree[v] && !vcComp[v] &&
          vcPrio[v*PRIO_W +: PRIO_W] > winPrio &&
          (!vicFound || vcPrio[v*PRIO_W +: PRIO_W] > vicPrio)) begin
        vicFound = 1'b1;
        vicPrio  = vcPrio[v*PRIO_W +: PRIO_W];
        dropVc   = VC_IW'(v);
      end
    end
  end

  always_comb begin
    strobe  = '0;
    grantVc = '0;
    if (winFound) begin
      if (winComp && vcFree[0]) begin
        strobe.grantEn = 1'b1;
        grantVc        = '0;
      end else if (genFound) begin
        strobe.grantEn = 1'b1;
        grantVc        = genVc;
      end else if (vicFound) begin
        strobe.dropEn = 1'b1;
      end
    end
  end
endmodule

// File: rtl/vcaPath.sv
module vcaPath
  import vcaPkg::*;
#(
  parameter int NUM_REQ  = 3,
  parameter int NUM_VC   = 4,
  parameter int VC_DEPTH = 4,
  parameter int PRIO_W   = 4,
  parameter int LEN_W    = 2,
  localparam int REQ_IW  = idxWidth(NUM_REQ),
  localparam int VC_IW   = idxWidth(NUM_VC),
  localparam int CRED_W  = $clog2(VC_DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  vcaStrobe_t               strobe,
  input  logic [VC_IW-1:0]         grantVc,
  input  logic [VC_IW-1:0]         dropVc,
  input  logic [REQ_IW-1:0]        winIdx,
  input  logic [PRIO_W-1:0]        winPrio,
  input  logic                     winComp,
  input  logic [LEN_W-1:0]         winLen,
  input  logic [NUM_VC-1:0]        creditRet,
  output logic [NUM_VC-1:0]        vcFree,
  output logic [NUM_VC*PRIO_W-1:0] vcPrio,
  output logic [NUM_VC-1:0]        vcComp,
  output logic [NUM_VC-1:0]        doneMask,
  output logic [REQ_IW-1:0]        dropSrc
);
  localparam logic [CRED_W-1:0] FULL = CRED_W'(VC_DEPTH);

  logic [REQ_IW-1:0] srcArr [NUM_VC];

  for (genvar v = 0; v < NUM_VC; v++) begin : gVc
    logic [CRED_W-1:0] credit;
    logic [PRIO_W-1:0] prio;
    logic              comp;
    logic [REQ_IW-1:0] src;
    logic              hitDrop;
    logic              hitGrant;

    assign hitDrop  = strobe.dropEn  && (dropVc  == VC_IW'(v));
    assign hitGrant = strobe.grantEn && (grantVc == VC_IW'(v));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        credit <= FULL;
        prio   <= '0;
        comp   <= 1'b0;
        src    <= '0;
      end else if (hitDrop) begin
        credit <= FULL;
      end else if (hitGrant) begin
        credit <= FULL - CRED_W'(winLen) - CRED_W'(1);
        prio   <= winPrio;
        comp   <= winComp;
        src    <= winIdx;
      end else if (creditRet[v] && credit != FULL) begin
        credit <= credit + CRED_W'(1);
      end
    end

    assign vcFree[v]                  = (credit == FULL);
    assign vcPrio[v*PRIO_W +: PRIO_W] = prio;
    assign vcComp[v]                  = comp;
    assign doneMask[v]                = creditRet[v] && !hitDrop && (credit == FULL - CRED_W'(1));
    assign srcArr[v]                  = src;
  end

  assign dropSrc = srcArr[dropVc];
endmodule

// File: rtl/vcPreemptAlloc.sv
module vcPreemptAlloc
  import vcaPkg::*;
#(
  parameter int NUM_REQ  = 3,
  parameter int NUM_VC   = 4,
  parameter int VC_DEPTH = 4,
  parameter int PRIO_W   = 4,
  localparam int LEN_W   = $clog2(VC_DEPTH),
  localparam int REQ_IW  = idxWidth(NUM_REQ),
  localparam int VC_IW   = idxWidth(NUM_VC)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_REQ-1:0]        reqValid,
  input  logic [NUM_REQ*PRIO_W-1:0] reqPrio,
  input  logic [NUM_REQ-1:0]        reqCompliant,
  input  logic [NUM_REQ*LEN_W-1:0]  reqLen,
  input  logic [NUM_VC-1:0]         creditRet,
  output logic                      grantValid,
  output logic [REQ_IW-1:0]         grantReq,
  output logic [VC_IW-1:0]          grantVc,
  output logic                      nackValid,
  output logic [VC_IW-1:0]          nackVc,
  output logic [REQ_IW-1:0]         nackSrc,
  output logic [NUM_VC-1:0]         doneMask
);
  vcaStrobe_t               strobe;
  logic [REQ_IW-1:0]        winIdx;
  logic [PRIO_W-1:0]        winPrio;
  logic                     winComp;
  logic [LEN_W-1:0]         winLen;
  logic [NUM_VC-1:0]        vcFree;
  logic [NUM_VC*PRIO_W-1:0] vcPrio;
  logic [NUM_VC-1:0]        vcComp;
  logic [VC_IW-1:0]         dropVc;

  vcaCtrl #(.NUM_REQ(NUM_REQ), .NUM_VC(NUM_VC), .PRIO_W(PRIO_W), .LEN_W(LEN_W)) ctrlI (
    .reqValid(reqValid), .reqPrio(reqPrio), .reqCompliant(reqCompliant), .reqLen(reqLen),
    .vcFree(vcFree), .vcPrio(vcPrio), .vcComp(vcComp),
    .strobe(strobe), .winIdx(winIdx), .winPrio(winPrio), .winComp(winComp),
    .winLen(winLen), .grantVc(grantVc), .dropVc(dropVc)
  );

  vcaPath #(.NUM_REQ(NUM_REQ), .NUM_VC(NUM_VC), .VC_DEPTH(VC_DEPTH), .PRIO_W(PRIO_W),
            .LEN_W(LEN_W)) pathI (
    .clk(clk), .rstN(rstN), .strobe(strobe), .grantVc(grantVc), .dropVc(dropVc),
    .winIdx(winIdx), .winPrio(winPrio), .winComp(winComp), .winLen(winLen),
    .creditRet(creditRet), .vcFree(vcFree), .vcPrio(vcPrio), .vcComp(vcComp),
    .doneMask(doneMask), .dropSrc(nackSrc)
  );

  assign grantValid = strobe.grantEn;
  assign grantReq   = winIdx;
  assign nackValid  = strobe.dropEn;
  assign nackVc     = dropVc;
endmodule

// File: rtl/vcPreemptAllocChk.sv
module vcPreemptAllocChk #(
  parameter int NUM_REQ = 3,
  parameter int REQ_IW  = 2,
  parameter int VC_IW   = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_REQ-1:0] reqValid,
  input logic [NUM_REQ-1:0] reqCompliant,
  input logic               grantValid,
  input logic [REQ_IW-1:0]  grantReq,
  input logic [VC_IW-1:0]   grantVc,
  input logic               nackValid,
  input logic [VC_IW-1:0]   nackVc
);
  assert_grant_requested_R2: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> reqValid[grantReq]);

  assert_reserved_compliant_R3: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && grantVc == '0) |-> reqCompliant[grantReq]);

  assert_granted_vc_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |=> !(grantValid && grantVc == $past(grantVc)));

  assert_nack_excludes_grant_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(grantValid && nackValid));

  assert_reserved_not_victim_R8: assert property (@(posedge clk) disable iff (!rstN)
    nackValid |-> nackVc != '0);

  assert_victim_freed_R9: assert property (@(posedge clk) disable iff (!rstN)
    nackValid |=> !(nackValid && nackVc == $past(nackVc)));
endmodule

bind vcPreemptAlloc vcPreemptAllocChk #(.NUM_REQ(NUM_REQ), .REQ_IW(REQ_IW), .VC_IW(VC_IW)) chkI (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCompliant(reqCompliant),
  .grantValid(grantValid), .grantReq(grantReq), .grantVc(grantVc),
  .nackValid(nackValid), .nackVc(nackVc)
);

// File: tb/vcPreemptAlloc_tb_top.sv
`timescale 1ns/1ps
module vcPreemptAlloc_tb_top;
  localparam int NR = 3, NV = 4, DEP = 4, PW = 3, LW = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NR-1:0] reqValid = '0;
  logic [NR*PW-1:0] reqPrio = '0;
  logic [NR-1:0] reqCompliant = '0;
  logic [NR*LW-1:0] reqLen = '0;
  logic [NV-1:0] creditRet = '0;
  logic          grantValid;
  logic [1:0]    grantReq;
  logic [1:0]    grantVc;
  logic          nackValid;
  logic [1:0]    nackVc;
  logic [1:0]    nackSrc;
  logic [NV-1:0] doneMask;

  int nTests = 0;
  int nFail  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  vcPreemptAlloc #(.NUM_REQ(NR), .NUM_VC(NV), .VC_DEPTH(DEP), .PRIO_W(PW)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPrio(reqPrio),
    .reqCompliant(reqCompliant), .reqLen(reqLen), .creditRet(creditRet),
    .grantValid(grantValid), .grantReq(grantReq), .grantVc(grantVc),
    .nackValid(nackValid), .nackVc(nackVc), .nackSrc(nackSrc), .doneMask(doneMask)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clearIn();
    reqValid = '0; reqPrio = '0; reqCompliant = '0; reqLen = '0; creditRet = '0;
  endtask

  task automatic setReq(input int i, input int p, input bit c, input int l);
    reqValid[i] = 1'b1;
    reqPrio[i*PW +: PW] = PW'(p);
    reqCompliant[i] = c;
    reqLen[i*LW +: LW] = LW'(l);
  endtask

  // drive one request, check its grant, let it take effect at the next edge
  task automatic commit(input int i, input int p, input bit c, input int l, input int expVc, input string tag);
    @(posedge clk); #1; clearIn(); setReq(i, p, c, l);
    @(negedge clk);
    chk({tag, " grantValid"}, grantValid, 1);
    chk({tag, " grantVc"}, grantVc, expVc);
  endtask

  // drive one request, check outputs, withdraw it before the edge
  task automatic probe(input int p, input bit c, input int expG, input int expVc,
                       input int expN, input int expNVc, input string tag);
    @(posedge clk); #1; clearIn(); setReq(0, p, c, 3);
    @(negedge clk);
    chk({tag, " grantValid"}, grantValid, expG);
    if (expG == 1) chk({tag, " grantVc"}, grantVc, expVc);
    chk({tag, " nackValid"}, nackValid, expN);
    if (expN == 1) chk({tag, " nackVc"}, nackVc, expNVc);
    #1 clearIn();
  endtask

  task automatic pulse(input int v, input int expDone, input string tag);
    @(posedge clk); #1; clearIn(); creditRet[v] = 1'b1;
    @(negedge clk);
    chk({tag, " doneMask"}, int'(doneMask[v]), expDone);
  endtask

  task automatic drain(input int v, input int n, input string tag);
    for (int k = 1; k <= n; k++) pulse(v, (k == n) ? 1 : 0, tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1: quiet after reset
    chk("R1 grantValid", grantValid, 0);
    chk("R1 nackValid", nackValid, 0);
    chk("R1 doneMask", doneMask, 0);

    // R2: exhaustive arbitration sweep (probes only)
    for (int m = 1; m < 8; m++) begin
      for (int pc = 0; pc < 512; pc++) begin
        int bestI;
        int bestP;
        bestI = -1; bestP = 0;
        @(posedge clk); #1; clearIn();
        for (int i = 0; i < NR; i++) begin
          int p;
          p = (pc >> (3 * i)) & 7;
          if (m[i]) begin
            setReq(i, p, 1'b0, 0);
            if (bestI < 0 || p < bestP) begin bestI = i; bestP = p; end
          end
        end
        @(negedge clk);
        chk("R2 grantValid", grantValid, 1);
        chk("R2 grantReq", grantReq, bestI);
        chk("R3 noncompliant lowest general", grantVc, 1);
        #1 clearIn();
      end
    end

    // R3 / R4 / R5: placement and credit return
    commit(0, 3, 1'b0, 0, 1, "R3 nc first");
    commit(1, 4, 1'b1, 3, 0, "R3 compliant reserved");
    commit(2, 5, 1'b0, 1, 2, "R4 held VC skipped");
    commit(0, 6, 1'b1, 3, 3, "R3 compliant fallback");
    drain(1, 1, "R5 one flit");
    drain(0, 4, "R5 four flits");
    drain(2, 2, "R5 two flits");
    drain(3, 4, "R5 four flits vc3");

    // R3 / R7 / R8 with three equal holders
    commit(0, 1, 1'b0, 3, 1, "R3 fill1");
    commit(0, 1, 1'b0, 3, 2, "R3 fill2");
    commit(0, 1, 1'b0, 3, 3, "R3 fill3");
    probe(1, 1'b0, 0, 0, 0, 0, "R8 equal priority");
    probe(5, 1'b1, 1, 0, 0, 0, "R3 reserved for compliant");
    probe(0, 1'b0, 0, 0, 1, 1, "R7 tie lowest index");
    drain(1, 4, "R5 d1"); drain(2, 4, "R5 d2"); drain(3, 4, "R5 d3");

    // R6 / R7 / R9: preempt and regrant
    commit(0, 2, 1'b0, 3, 1, "R6 fillA");
    commit(1, 6, 1'b0, 3, 2, "R6 fillB");
    commit(1, 6, 1'b0, 3, 3, "R6 fillC");
    @(posedge clk); #1; clearIn(); setReq(2, 1, 1'b0, 3);
    @(negedge clk);
    chk("R6 nackValid", nackValid, 1);
    chk("R7 nackVc", nackVc, 2);
    chk("R6 nackSrc", nackSrc, 1);
    chk("R6 no grant", grantValid, 0);
    @(negedge clk);
    chk("R9 grantValid", grantValid, 1);
    chk("R9 grantVc", grantVc, 2);
    chk("R9 grantReq", grantReq, 2);
    chk("R9 nackValid", nackValid, 0);
    probe(3, 1'b0, 0, 0, 1, 3, "R7 worst remaining");
    drain(1, 4, "R5 e1"); drain(2, 4, "R5 e2"); drain(3, 4, "R5 e3");

    // R8: compliant holders are never victims
    commit(0, 7, 1'b1, 3, 0, "R8 c0");
    commit(0, 7, 1'b1, 3, 1, "R8 c1");
    commit(0, 7, 1'b1, 3, 2, "R8 c2");
    commit(0, 7, 1'b1, 3, 3, "R8 c3");
    probe(0, 1'b0, 0, 0, 0, 0, "R8 nc vs compliant");
    probe(0, 1'b1, 0, 0, 0, 0, "R8 c vs compliant");
    drain(0, 4, "R5 f0"); drain(1, 4, "R5 f1"); drain(2, 4, "R5 f2"); drain(3, 4, "R5 f3");

    // R4 / R5: every packet length
    for (int l = 0; l < 4; l++) begin
      commit(0, 7, 1'b0, l, 1, "R4 len sweep a");
      commit(1, 7, 1'b0, 3, 2, "R4 len sweep b");
      commit(1, 7, 1'b0, 3, 3, "R4 len sweep c");
      for (int k = 1; k <= l + 1; k++) begin
        pulse(1, (k == l + 1) ? 1 : 0, "R5 len sweep");
        if (k < l + 1) probe(7, 1'b0, 0, 0, 0, 0, "R4 still held");
      end
      probe(7, 1'b0, 1, 1, 0, 0, "R4 freed after credits");
      drain(2, 4, "R5 g2"); drain(3, 4, "R5 g3");
    end

    @(posedge clk); #1 clearIn();
    repeat (2) @(posedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule